// File: doc/BRIEF.md
# DAC Code Holding Register Front End

This block sits between a 16-bit register bus and a 12-bit digital-to-analog converter. Software writes a conversion code into a holding buffer. The code reaches the converter input later. With the sync mode off, it moves one clock after it is held. With the sync mode on, it moves on a synchronized rising edge of an external trigger pin. That trigger lets several converters, or a converter and a timer, change output in step.

A control register selects right- or left-justified data layout, the sync mode, and a power-down state. Power-down starts asserted after reset and keeps the analog output disabled. Changing power-down does not disturb any register. When power-down is released, a ready flag stays low for a programmable settle interval and then rises. Reads of the data register return the code that is actually driving the converter. This can differ from the code waiting in the holding buffer.

Top module: `dac_data_regif`

## Requirements
- R1: After reset the control register reads 0x0001 (power-down set, right-justified, sync mode off), the presented code and data read are zero, and `dac_out_en` and `dac_ready` are low.
- R2: A write to the data register (`reg_sel`=1) only loads the holding buffer; with sync mode on and no trigger edge, `dac_code` and the data read-back keep their previous value.
- R3: With sync mode off, the holding buffer appears on `dac_code` one clock after the write edge.
- R4: With sync mode on, the holding buffer moves to `dac_code` on the third rising clock edge after `sync_in` rises (two synchronizer flops plus the transfer register); a held-high or falling `sync_in` moves nothing.
- R5: A trigger edge with no new data write since the last transfer presents the same code again, and `dac_code` stays unchanged.
- R6: A read of the data register returns the presented code, not the pending holding buffer.
- R7: Right-justified format (control bit 1 = 0): a write takes the code from `wdata[11:0]`; a read returns the code in bits 11..0 with bits 15..12 zero.
- R8: Left-justified format (control bit 1 = 1): a write takes the code from `wdata[15:4]`; a read returns the code in bits 15..4 with bits 3..0 zero; the format in effect at write time decides the realignment.
- R9: The control register is at `reg_sel`=0; bit 0 is power-down, bit 1 is format, bit 2 is sync mode, and bits 15..3 read as zero.
- R10: `dac_out_en` is the inverse of the power-down bit; setting or clearing power-down changes neither `dac_code` nor the other control bits.
- R11: `dac_ready` is low while powered down and rises exactly SETTLE_US x CLK_MHZ clock cycles after the write edge that clears power-down (600 cycles at the defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register select: 0 control, 1 data |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register (combinational) |
| sync_in | input | 1 | Asynchronous transfer trigger, rising edge active |
| dac_code | output | 12 | Code presented to the converter input |
| dac_out_en | output | 1 | Analog output enable (low drives output low) |
| dac_ready | output | 1 | Converter settled after power-up |

## Verification
On every cycle, the assertions check the read layouts of both registers. They check that the output enable agrees with the power-down bit as read back. They also check that, in sync mode, the presented code only changes after a detected trigger edge. Finally, they check that the ready flag never rises before the settle count or while powered down. Some behaviour only the bench scenarios can show. This covers the exact transfer latency in each mode and realignment by the format in force at write time. It also covers retention of the code across power-down, and read-back of the presented code while a different code is pending.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int unsigned BUS_W   = 16;
  localparam int unsigned CODE_W  = 12;
  localparam int unsigned PAD_W   = BUS_W - CODE_W;

  localparam logic SEL_CTRL = 1'b0;
  localparam logic SEL_DATA = 1'b1;

  localparam int unsigned CTRL_PDN_BIT  = 0;
  localparam int unsigned CTRL_FMT_BIT  = 1;
  localparam int unsigned CTRL_SYNC_BIT = 2;

  typedef struct packed {
    logic sync_en;
    logic fmt_left;
    logic pdn;
  } dac_ctrl_t;

  localparam dac_ctrl_t CTRL_RESET = '{sync_en: 1'b0, fmt_left: 1'b0, pdn: 1'b1};
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dac_sync_edge.sv
module dac_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] pipe_q;
  logic [STAGES:0] pipe_d;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        assign pipe_d[i] = async_in;
      end else begin : g_next
        assign pipe_d[i] = pipe_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dac_xfer.sv
module dac_xfer
  import dac_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              fmt_left,
  input  logic              sync_en,
  input  logic              sync_rise,
  output logic [CODE_W-1:0] code
);
  logic [CODE_W-1:0] hold_q, hold_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] aligned;
  logic              take;

  always_comb begin
    aligned = fmt_left ? wdata[BUS_W-1:PAD_W] : wdata[CODE_W-1:0];
    hold_d  = load ? aligned : hold_q;
    take    = sync_en ? sync_rise : 1'b1;
    code_d  = take ? hold_q : code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      code_q <= '0;
    end else begin
      hold_q <= hold_d;
      code_q <= code_d;
    end
  end

  assign code = code_q;
endmodule

// File: rtl/dac_settle_timer.sv
module dac_settle_timer #(
  parameter int unsigned CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pdn,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done;

  always_comb begin
    done = (cnt_q == LIMIT);
    if (pdn)       cnt_d = '0;
    else if (done) cnt_d = cnt_q;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready = done & ~pdn;
endmodule

// File: rtl/dac_data_regif.sv
module dac_data_regif
  import dac_regif_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 60,
  parameter int unsigned SETTLE_US   = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              wr_en,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              sync_in,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_out_en,
  output logic              dac_ready
);
  localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

  logic      rst_sync_n;
  dac_ctrl_t ctrl_q, ctrl_d;
  logic      ctrl_we, data_we;
  logic      sync_rise;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    ctrl_we = wr_en & (reg_sel == SEL_CTRL);
    data_we = wr_en & (reg_sel == SEL_DATA);
    ctrl_d  = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.pdn      = wdata[CTRL_PDN_BIT];
      ctrl_d.fmt_left = wdata[CTRL_FMT_BIT];
      ctrl_d.sync_en  = wdata[CTRL_SYNC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ctrl_q <= CTRL_RESET;
    else             ctrl_q <= ctrl_d;
  end

  dac_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (sync_in),
    .rise     (sync_rise)
  );

  dac_xfer u_xfer (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (data_we),
    .wdata     (wdata),
    .fmt_left  (ctrl_q.fmt_left),
    .sync_en   (ctrl_q.sync_en),
    .sync_rise (sync_rise),
    .code      (dac_code)
  );

  dac_settle_timer #(.CYCLES(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .pdn   (ctrl_q.pdn),
    .ready (dac_ready)
  );

  always_comb begin
    rdata = '0;
    if (reg_sel == SEL_CTRL) begin
      rdata[CTRL_PDN_BIT]  = ctrl_q.pdn;
      rdata[CTRL_FMT_BIT]  = ctrl_q.fmt_left;
      rdata[CTRL_SYNC_BIT] = ctrl_q.sync_en;
    end else if (ctrl_q.fmt_left) begin
      rdata = {dac_code, {PAD_W{1'b0}}};
    end else begin
      rdata = {{PAD_W{1'b0}}, dac_code};
    end
  end

  assign dac_out_en = ~ctrl_q.pdn;
endmodule

// File: rtl/dac_regif_chk.sv
module dac_regif_chk
  import dac_regif_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_sel,
  input logic [BUS_W-1:0]  rdata,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_out_en,
  input logic              dac_ready,
  input logic              sync_en,
  input logic              fmt_left,
  input logic              sync_rise
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] on_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               on_cnt_q <= '0;
    else if (!dac_out_en)     on_cnt_q <= '0;
    else if (on_cnt_q != LIMIT) on_cnt_q <= on_cnt_q + 1'b1;
  end

  // R9
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CTRL) |-> (rdata[BUS_W-1:3] == '0));

  // R10
  out_en_matches_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_CTRL) |-> (rdata[CTRL_PDN_BIT] == !dac_out_en));

  // R7
  right_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_DATA && !fmt_left) |-> (rdata[BUS_W-1:CODE_W] == '0));

  // R8
  left_pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_DATA && fmt_left) |-> (rdata[PAD_W-1:0] == '0));

  // R4
  sync_only_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !sync_rise) |=> $stable(dac_code));

  // R11
  ready_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dac_ready |-> dac_out_en);

  // R11
  ready_after_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_ready) |-> (on_cnt_q == LIMIT));
endmodule

bind dac_data_regif dac_regif_chk #(.SETTLE_CYC(CLK_MHZ * SETTLE_US)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .reg_sel    (reg_sel),
  .rdata      (rdata),
  .dac_code   (dac_code),
  .dac_out_en (dac_out_en),
  .dac_ready  (dac_ready),
  .sync_en    (ctrl_q.sync_en),
  .fmt_left   (ctrl_q.fmt_left),
  .sync_rise  (sync_rise)
);

// File: tb/dac_data_regif_tb.sv
module dac_data_regif_tb;
  localparam int unsigned SETTLE = 600;

  logic        clk;
  logic        rst_n;
  logic        reg_sel;
  logic        wr_en;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        sync_in;
  logic [11:0] dac_code;
  logic        dac_out_en;
  logic        dac_ready;

  int n_chk;
  int n_bad;

  logic        m_pdn, m_fmt, m_sync;
  logic [11:0] m_hold, m_code;

  dac_data_regif u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_sel    (reg_sel),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .sync_in    (sync_in),
    .dac_code   (dac_code),
    .dac_out_en (dac_out_en),
    .dac_ready  (dac_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] exp_ctrl();
    return {13'b0, m_sync, m_fmt, m_pdn};
  endfunction

  function automatic logic [15:0] exp_data();
    return m_fmt ? {m_code, 4'b0} : {4'b0, m_code};
  endfunction

  function automatic logic [11:0] align(input logic [15:0] w, input logic f);
    return f ? w[15:4] : w[11:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_chk(input string req, input logic sel, input logic [15:0] exp);
    reg_sel = sel;
    #0.5;
    check(req, rdata, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    if (!m_sync) m_code = m_hold;
  endtask

  task automatic bus_wr(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel;
    wdata   = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (sel) m_hold = align(d, m_fmt);
    else begin
      m_pdn = d[0]; m_fmt = d[1]; m_sync = d[2];
    end
  endtask

  task automatic pulse_sync();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R4 before edge", {4'b0, dac_code}, {4'b0, m_code});
    @(negedge clk);
    m_code = m_hold;
    check("R4 after edge", {4'b0, dac_code}, {4'b0, m_code});
    sync_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; reg_sel = 1'b0; wr_en = 1'b0; wdata = '0; sync_in = 1'b0;
    m_pdn = 1'b1; m_fmt = 1'b0; m_sync = 1'b0; m_hold = '0; m_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_chk("R1 ctrl", 1'b0, 16'h0001);
    read_chk("R1 data", 1'b1, 16'h0000);
    check("R1 out_en", {15'b0, dac_out_en}, 16'h0);
    check("R1 ready", {15'b0, dac_ready}, 16'h0);

    // R9 upper ctrl bits ignored on write
    bus_wr(1'b0, 16'hFFF9);
    read_chk("R9 ctrl layout", 1'b0, 16'h0001);

    // R3 immediate transfer, right-justified (R7)
    bus_wr(1'b1, 16'hFABC);
    check("R3 not before next edge", {4'b0, dac_code}, 16'h0000);
    tick();
    check("R3 code", {4'b0, dac_code}, 16'h0ABC);
    read_chk("R7 right read", 1'b1, 16'h0ABC);

    // R8 left-justified write and read
    bus_wr(1'b0, 16'h0003);
    tick();
    read_chk("R8 left read of old code", 1'b1, 16'hABC0);
    bus_wr(1'b1, 16'h1235);
    tick();
    check("R8 left write", {4'b0, dac_code}, 16'h0123);
    read_chk("R8 left read", 1'b1, 16'h1230);

    // R2/R6 sync mode, right-justified: pending differs from presented
    bus_wr(1'b0, 16'h0005);
    tick();
    bus_wr(1'b1, 16'h0777);
    repeat (4) tick();
    check("R2 buffered only", {4'b0, dac_code}, {4'b0, m_code});
    read_chk("R6 read presented", 1'b1, exp_data());
    pulse_sync();
    read_chk("R6 read after edge", 1'b1, 16'h0777);

    // R4 held-high sync moves nothing
    bus_wr(1'b1, 16'h0456);
    @(negedge clk); sync_in = 1'b1;
    repeat (4) @(negedge clk);
    m_code = m_hold;
    check("R4 first edge", {4'b0, dac_code}, 16'h0456);
    bus_wr(1'b1, 16'h0999);
    repeat (6) @(negedge clk);
    check("R4 held high no move", {4'b0, dac_code}, 16'h0456);
    sync_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R4 falling no move", {4'b0, dac_code}, 16'h0456);

    // R5 repeated edge without a write
    pulse_sync();
    pulse_sync();
    check("R5 same code", {4'b0, dac_code}, 16'h0999);

    // R10/R11 power-up and settle
    bus_wr(1'b0, 16'h0004);
    check("R10 out_en", {15'b0, dac_out_en}, 16'h1);
    check("R10 code kept", {4'b0, dac_code}, 16'h0999);
    read_chk("R10 ctrl kept", 1'b0, 16'h0004);
    repeat (SETTLE - 1) @(negedge clk);
    check("R11 not yet ready", {15'b0, dac_ready}, 16'h0);
    @(negedge clk);
    check("R11 ready", {15'b0, dac_ready}, 16'h1);
    bus_wr(1'b0, 16'h0005);
    check("R11 ready drops", {15'b0, dac_ready}, 16'h0);
    check("R10 out_en low", {15'b0, dac_out_en}, 16'h0);
    check("R10 code kept pdn", {4'b0, dac_code}, 16'h0999);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [15:0] c, d;
      c = {13'b0, 3'($urandom)};
      d = 16'($urandom);
      bus_wr(1'b0, c);
      tick();
      bus_wr(1'b1, d);
      tick();
      if (m_sync && ($urandom % 2 == 1)) pulse_sync();
      check("R3/R4 random code", {4'b0, dac_code}, {4'b0, m_code});
      read_chk(m_fmt ? "R8 random read" : "R7 random read", 1'b1, exp_data());
      read_chk("R9 random ctrl", 1'b0, exp_ctrl());
      check("R10 random out_en", {15'b0, dac_out_en}, {15'b0, ~m_pdn});
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule